// File: doc/BRIEF.md
# 4B/5B Transmit Encoder with Stream Delimiters

This block sits in the transmit path of a 100 Mb/s Fast Ethernet physical layer. Each transmit clock it takes one nibble from the MAC side (enable, error and four data bits) and produces one 5-bit code group. Between frames it sends the idle group. When the enable goes high, the first two nibbles of the frame are replaced by the start-of-stream pair J then K. The data nibbles that follow are mapped through the 4B/5B table. A nibble flagged as errored becomes the error symbol H. When the enable drops, the block appends the end-of-stream pair T then R and then goes back to idle.

A raw mode passes the nibble through unmapped, with the error flag as the top bit. This mode is available only while the MAC link runs in MII mode. The code group output is registered. Scrambling, line coding and serialization happen downstream. Bit 4 of the output is the first bit sent on the line.

Top module: `tx45_encoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the output is the idle group 11111.
- R2: With the enable low and no frame in progress, the output stays 11111, whatever the error flag and data bits are.
- R3: When the enable rises from idle, the output for that nibble is J (11000) and the output for the next nibble is K (10001). Both replace data.
- R4: After J/K, each nibble sent with the enable high and the error flag low is output as its 4B/5B group, one clock after it is presented. Nibbles 0 to F map to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: A data nibble presented with both the enable and the error flag high is output as H (00100) in place of its data group.
- R6: The first nibble slot with the enable low after data produces T (01101). The next slot produces R (00111), and idle follows until the enable rises again.
- R7: If the enable drops right after the J slot, the output is still K, then T, then R, then idle.
- R8: With raw mode requested and MII mode set, the output one clock later is {error flag, data[3:0]}, with no mapping and no delimiters.
- R9: With raw mode requested but MII mode clear, the request is ignored and the normal encoding of R2 to R6 applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEn | input | 1 | Frame enable from the MAC |
| txEr | input | 1 | Transmit error flag from the MAC |
| txData | input | 4 | Transmit nibble |
| bypassReq | input | 1 | Raw (unencoded) mode request |
| miiMode | input | 1 | High when the MAC link runs in MII mode |
| codeOut | output | 5 | Registered code group, bit 4 sent first |

## Verification
A frame carrying every nibble 0 to F exercises the whole mapping, so a single swapped or mistyped table entry shows up. A frame with one errored nibble in the middle shows that H replaces only that slot and that the neighbouring data groups are unaffected. A one-nibble frame separates a controller that always finishes J/K and T/R from one that jumps straight from J to T. Raw mode is run both with and without MII mode. This shows that the pass-through is gated, and error-flag toggling during idle shows that the flag has no effect outside a frame.

// File: rtl/tx45_pkg.sv
package tx45_pkg;
  localparam int NIBBLE_W = 4;
  localparam int CODE_W   = NIBBLE_W + 1;

  localparam logic [CODE_W-1:0] CODE_IDLE = 5'b11111;
  localparam logic [CODE_W-1:0] CODE_J    = 5'b11000;
  localparam logic [CODE_W-1:0] CODE_K    = 5'b10001;
  localparam logic [CODE_W-1:0] CODE_T    = 5'b01101;
  localparam logic [CODE_W-1:0] CODE_R    = 5'b00111;
  localparam logic [CODE_W-1:0] CODE_H    = 5'b00100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K, ST_DATA, ST_T, ST_R
  } encStateT;

  // one-hot strobes from control to datapath
  typedef struct packed {
    logic selIdle;
    logic selJ;
    logic selK;
    logic selT;
    logic selR;
    logic selErr;
    logic selData;
    logic selRaw;
  } strobeT;

  function automatic logic [CODE_W-1:0] mapNibble(input logic [NIBBLE_W-1:0] nib);
    logic [CODE_W-1:0] grp;
    case (nib)
      4'h0: grp = 5'b11110;
      4'h1: grp = 5'b01001;
      4'h2: grp = 5'b10100;
      4'h3: grp = 5'b10101;
      4'h4: grp = 5'b01010;
      4'h5: grp = 5'b01011;
      4'h6: grp = 5'b01110;
      4'h7: grp = 5'b01111;
      4'h8: grp = 5'b10010;
      4'h9: grp = 5'b10011;
      4'hA: grp = 5'b10110;
      4'hB: grp = 5'b10111;
      4'hC: grp = 5'b11010;
      4'hD: grp = 5'b11011;
      4'hE: grp = 5'b11100;
      default: grp = 5'b11101;
    endcase
    return grp;
  endfunction
endpackage

// File: rtl/tx45_ctrl.sv
module tx45_ctrl
  import tx45_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   txEn,
  input  logic   txEr,
  input  logic   encOn,
  output strobeT stb
);
  encStateT state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    if (!encOn) begin
      stb.selRaw = 1'b1;
      stateNext  = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (txEn) begin
            stb.selJ  = 1'b1;
            stateNext = ST_K;
          end else begin
            stb.selIdle = 1'b1;
          end
        end
        ST_K: begin
          stb.selK  = 1'b1;
          stateNext = txEn ? ST_DATA : ST_T;
        end
        ST_DATA: begin
          if (txEn) begin
            if (txEr) stb.selErr  = 1'b1;
            else      stb.selData = 1'b1;
          end else begin
            stb.selT  = 1'b1;
            stateNext = ST_R;
          end
        end
        ST_T: begin
          stb.selT  = 1'b1;
          stateNext = ST_R;
        end
        default: begin
          stb.selR  = 1'b1;
          stateNext = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/tx45_dpath.sv
module tx45_dpath
  import tx45_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              stb,
  input  logic                txEr,
  input  logic [NIBBLE_W-1:0] txData,
  output logic [CODE_W-1:0]   codeOut
);
  logic [CODE_W-1:0] codeNext;

  always_comb begin
    codeNext = CODE_IDLE;
    if (stb.selRaw)       codeNext = {txEr, txData};
    else if (stb.selJ)    codeNext = CODE_J;
    else if (stb.selK)    codeNext = CODE_K;
    else if (stb.selT)    codeNext = CODE_T;
    else if (stb.selR)    codeNext = CODE_R;
    else if (stb.selErr)  codeNext = CODE_H;
    else if (stb.selData) codeNext = mapNibble(txData);
  end

  always_ff @(posedge clk) begin
    if (!rstN) codeOut <= CODE_IDLE;
    else       codeOut <= codeNext;
  end
endmodule

// File: rtl/tx45_encoder.sv
module tx45_encoder
  import tx45_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txEn,
  input  logic        txEr,
  input  logic [3:0]  txData,
  input  logic        bypassReq,
  input  logic        miiMode,
  output logic [4:0]  codeOut
);
  strobeT stb;
  logic   encOn;

  assign encOn = !(bypassReq && miiMode);

  tx45_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .txEn  (txEn),
    .txEr  (txEr),
    .encOn (encOn),
    .stb   (stb)
  );

  tx45_dpath u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .txEr    (txEr),
    .txData  (txData),
    .codeOut (codeOut)
  );
endmodule

// File: rtl/tx45_checker.sv
module tx45_checker
  import tx45_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       txEn,
  input logic       txEr,
  input logic [3:0] txData,
  input logic       bypassReq,
  input logic       miiMode,
  input logic [4:0] codeOut
);
  logic rawOn;
  assign rawOn = bypassReq && miiMode;

  // R3
  j_then_k_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == CODE_J && !$past(rawOn) && !rawOn) |=> codeOut == CODE_K);

  // R6
  t_then_r_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == CODE_T && !$past(rawOn) && !rawOn) |=> codeOut == CODE_R);

  // R8
  raw_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    rawOn |=> codeOut == {$past(txEr), $past(txData)});

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == CODE_IDLE && !txEn && !rawOn && !$past(rawOn)) |=> codeOut == CODE_IDLE);

  // R5
  err_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == CODE_H && !$past(rawOn)) |-> ($past(txEr) && $past(txEn)));
endmodule

bind tx45_encoder tx45_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .txEn      (txEn),
  .txEr      (txEr),
  .txData    (txData),
  .bypassReq (bypassReq),
  .miiMode   (miiMode),
  .codeOut   (codeOut)
);

// File: tb/sim_tx45_encoder.sv
module sim_tx45_encoder;
  logic       clk = 1'b0;
  logic       rstN;
  logic       txEn, txEr, bypassReq, miiMode;
  logic [3:0] txData;
  logic [4:0] codeOut;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  tx45_encoder u0 (
    .clk(clk), .rstN(rstN), .txEn(txEn), .txEr(txEr), .txData(txData),
    .bypassReq(bypassReq), .miiMode(miiMode), .codeOut(codeOut)
  );

  function automatic logic [4:0] expMap(input logic [3:0] n);
    logic [4:0] lut [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                             5'b01010, 5'b01011, 5'b01110, 5'b01111,
                             5'b10010, 5'b10011, 5'b10110, 5'b10111,
                             5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return lut[n];
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    total++;
    if (codeOut !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, codeOut, exp);
    end
  endtask

  // drive at negedge, result visible at following negedge
  task automatic step(input logic en, input logic er, input logic [3:0] d);
    txEn = en; txEr = er; txData = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 0; txEn = 0; txEr = 0; txData = 0; bypassReq = 0; miiMode = 1;
    repeat (3) @(negedge clk);
    check("R1 in reset", 5'b11111);
    rstN = 1;
    step(0, 0, 4'h0);
    check("R1 after reset", 5'b11111);
  endtask

  task automatic testIdleErr();
    step(0, 1, 4'h5); check("R2 error flag outside frame", 5'b11111);
    step(0, 0, 4'hA); check("R2 data outside frame", 5'b11111);
  endtask

  task automatic testFullFrame();
    step(1, 0, 4'h5); check("R3 J", 5'b11000);
    step(1, 0, 4'h5); check("R3 K", 5'b10001);
    for (int i = 0; i < 16; i++) begin
      step(1, 0, 4'(i)); check("R4 data map", expMap(4'(i)));
    end
    step(0, 0, 4'h0); check("R6 T", 5'b01101);
    step(0, 0, 4'h0); check("R6 R", 5'b00111);
    step(0, 0, 4'h0); check("R6 idle after", 5'b11111);
    step(0, 0, 4'h0); check("R6 idle held", 5'b11111);
  endtask

  task automatic testErrFrame();
    step(1, 1, 4'h5); check("R5 J despite error", 5'b11000);
    step(1, 0, 4'hD); check("R5 K", 5'b10001);
    step(1, 0, 4'h3); check("R5 before", expMap(4'h3));
    step(1, 1, 4'h3); check("R5 H", 5'b00100);
    step(1, 0, 4'h9); check("R5 after", expMap(4'h9));
    step(0, 1, 4'h0); check("R6 T", 5'b01101);
    step(0, 0, 4'h0); check("R6 R", 5'b00111);
    step(0, 0, 4'h0); check("R6 idle", 5'b11111);
  endtask

  task automatic testShortFrame();
    step(1, 0, 4'h5); check("R7 J", 5'b11000);
    step(0, 0, 4'h0); check("R7 K", 5'b10001);
    step(0, 0, 4'h0); check("R7 T", 5'b01101);
    step(0, 0, 4'h0); check("R7 R", 5'b00111);
    step(0, 0, 4'h0); check("R7 idle", 5'b11111);
  endtask

  task automatic testRaw();
    bypassReq = 1; miiMode = 1;
    step(0, 0, 4'h3); check("R8 raw", 5'b00011);
    step(1, 1, 4'hC); check("R8 raw err bit", 5'b11100);
    step(1, 0, 4'h0); check("R8 raw no J", 5'b00000);
    step(0, 1, 4'hF); check("R8 raw", 5'b11111);
    step(0, 0, 4'h6); check("R8 raw", 5'b00110);
    bypassReq = 0;
    step(0, 0, 4'h6); check("R8 back to idle", 5'b11111);
  endtask

  task automatic testRawNoMii();
    bypassReq = 1; miiMode = 0;
    step(0, 1, 4'h3); check("R9 idle kept", 5'b11111);
    step(1, 0, 4'h3); check("R9 J", 5'b11000);
    step(1, 0, 4'h3); check("R9 K", 5'b10001);
    step(1, 0, 4'h7); check("R9 mapped", expMap(4'h7));
    step(0, 0, 4'h0); check("R9 T", 5'b01101);
    step(0, 0, 4'h0); check("R9 R", 5'b00111);
    bypassReq = 0; miiMode = 1;
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testIdleErr();
    testFullFrame();
    testErrFrame();
    testShortFrame();
    testRaw();
    testRawNoMii();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule